// File: doc/BRIEF.md
# Four-Entry Byte Register Memory

This block is a very small synchronous memory made of four byte-wide storage registers sharing one 2-bit address. A write strobe stores the input byte into the addressed register on the rising clock edge. A separate read strobe drives that register's contents onto the output. The write and read strobes are independent, and both act on the one shared address.

Every register sees the input byte at all times. Only the register whose address decode matches, while the write strobe is high, takes the byte. The other registers recirculate their own value. Reads are combinational from the stored contents. A read of the address being written in the same cycle therefore shows the value stored before that edge. While the read strobe is low, the output is forced to zero and the valid flag stays low.

Top module: `quad_byte_store`

## Requirements
- R1: A synchronous active-high reset clears all four registers to 0x00, so a read of any address after reset returns 0x00.
- R2: When `save` is 1 at a rising clock edge, the register selected by `addr` (value 0 to 3) takes `wr_data`.
- R3: A write to one address leaves the contents of the other three registers unchanged.
- R4: When `save` is 0 at an edge, every register keeps its contents, whatever `wr_data` carries.
- R5: While `load` is 1, `rd_data` equals the contents of the register selected by `addr`, and `rd_valid` is 1.
- R6: While `load` is 0, `rd_data` is 0x00 and `rd_valid` is 0.
- R7: When `save` and `load` are both 1 on the same address, `rd_data` shows the old contents in that cycle and the new byte from the next cycle on.
- R8: Reading never changes storage, and writing does not need `load`: a byte written while `load` is 0 is read back later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_data | input | 8 | Byte offered to all registers |
| addr | input | 2 | Register select, 0 to 3 |
| save | input | 1 | Write strobe |
| load | input | 1 | Read strobe |
| rd_data | output | 8 | Selected register contents, or 0x00 when not reading |
| rd_valid | output | 1 | High while a read is active |

## Verification
The hardest case to show from the ports is that a write did not disturb the registers it did not address. Storage is visible only through one shared address, and a write uses that same address. The stimulus first fills all four registers with distinct bytes, some of them with `load` low. It then rewrites one address and reads the other three back one at a time. It also drives `save` and `load` together on one address and checks the old value in that cycle and the new value in the following cycle.

// File: rtl/quad_byte_store.sv
module quad_byte_store #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        addr,
  input  logic              save,
  input  logic              load,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  localparam int ENTRIES = 4;

  logic [DATA_W-1:0] store [ENTRIES];
  logic [DATA_W-1:0] gated [ENTRIES];
  logic [ENTRIES-1:0] wen;
  logic [DATA_W-1:0] low_pair, high_pair;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    localparam bit HI = i[1];
    localparam bit LO = i[0];

    assign wen[i] = (HI ? addr[1] : ~addr[1]) & (LO ? addr[0] : ~addr[0]) & save;

    always_ff @(posedge clk) begin
      if (rst)
        store[i] <= '0;
      else if (wen[i])
        store[i] <= wr_data;
    end

    assign gated[i] = load ? store[i] : '0;
  end

  assign low_pair  = addr[0] ? gated[1] : gated[0];
  assign high_pair = addr[0] ? gated[3] : gated[2];
  assign rd_data   = addr[1] ? high_pair : low_pair;
  assign rd_valid  = load;

endmodule

module quad_byte_store_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] wr_data,
  input logic [1:0]        addr,
  input logic              save,
  input logic              load,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid
);

  assert_idle_zero_R6: assert property (@(posedge clk) disable iff (rst)
    !load |-> (rd_data == '0 && !rd_valid));

  assert_read_valid_R5: assert property (@(posedge clk) disable iff (rst)
    load |-> rd_valid);

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && load) |-> rd_data == '0);

  assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(save) && load && addr == $past(addr)) |-> rd_data == $past(wr_data));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(load) && !$past(save) && load && addr == $past(addr))
      |-> rd_data == $past(rd_data));

endmodule

bind quad_byte_store quad_byte_store_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .wr_data(wr_data), .addr(addr),
  .save(save), .load(load), .rd_data(rd_data), .rd_valid(rd_valid)
);

// File: tb/quad_byte_store_tb_top.sv
module quad_byte_store_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] wr_data = '0;
  logic [1:0] addr = '0;
  logic       save = 1'b0;
  logic       load = 1'b0;
  logic [7:0] rd_data;
  logic       rd_valid;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  quad_byte_store dut_i (
    .clk(clk), .rst(rst), .wr_data(wr_data), .addr(addr),
    .save(save), .load(load), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // {save, load, addr, wr_data, exp_valid, exp_data}
  localparam int NV = 16;
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 1'b0, 2'd0, 8'h11, 1'b0, 8'h00},  // R6 write with no read, R8
    {1'b1, 1'b1, 2'd1, 8'h22, 1'b1, 8'h00},  // R7 old value
    {1'b1, 1'b1, 2'd2, 8'h33, 1'b1, 8'h00},  // R7
    {1'b1, 1'b0, 2'd3, 8'h44, 1'b0, 8'h00},  // R6
    {1'b0, 1'b1, 2'd0, 8'hFF, 1'b1, 8'h11},  // R2 R8
    {1'b0, 1'b1, 2'd1, 8'hFF, 1'b1, 8'h22},  // R2
    {1'b0, 1'b1, 2'd2, 8'hFF, 1'b1, 8'h33},  // R2
    {1'b0, 1'b1, 2'd3, 8'hFF, 1'b1, 8'h44},  // R2 R8
    {1'b1, 1'b1, 2'd1, 8'hA5, 1'b1, 8'h22},  // R7 old
    {1'b0, 1'b1, 2'd1, 8'h00, 1'b1, 8'hA5},  // R7 new
    {1'b0, 1'b1, 2'd0, 8'h00, 1'b1, 8'h11},  // R3
    {1'b0, 1'b0, 2'd2, 8'h77, 1'b0, 8'h00},  // R4 R6
    {1'b0, 1'b1, 2'd2, 8'h00, 1'b1, 8'h33},  // R4
    {1'b1, 1'b0, 2'd0, 8'h5A, 1'b0, 8'h00},  // R6
    {1'b0, 1'b1, 2'd0, 8'h00, 1'b1, 8'h5A},  // R2 R5
    {1'b0, 1'b1, 2'd3, 8'h00, 1'b1, 8'h44}   // R3
  };
  localparam int TAG [NV] = '{6, 7, 7, 6, 2, 2, 2, 2, 7, 7, 3, 4, 4, 6, 5, 3};

  task automatic check(input string req, input logic v, input logic [7:0] d,
                       input logic ev, input logic [7:0] ed);
    checks++;
    if (v !== ev || d !== ed) begin
      errors++;
      $display("FAIL %s valid=%0b data=%02h expected valid=%0b data=%02h", req, v, d, ev, ed);
    end
  endtask

  task automatic drive(input logic s, input logic l, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    save = s; load = l; addr = a; wr_data = d;
    #1;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: storage is clear after reset, R6 idle output
    drive(1'b0, 1'b0, 2'd0, 8'h00);
    check("R6", rd_valid, rd_data, 1'b0, 8'h00);
    for (int a = 0; a < 4; a++) begin
      drive(1'b0, 1'b1, 2'(a), 8'hC3);
      check("R1", rd_valid, rd_data, 1'b1, 8'h00);
    end

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][20], VEC[i][19], VEC[i][18:17], VEC[i][16:9]);
      check($sformatf("R%0d", TAG[i]), rd_valid, rd_data, VEC[i][8], VEC[i][7:0]);
    end

    // R3: overwrite entry 2, then confirm the others
    drive(1'b1, 1'b0, 2'd2, 8'hE7);
    drive(1'b0, 1'b1, 2'd2, 8'h00);
    check("R2", rd_valid, rd_data, 1'b1, 8'hE7);
    drive(1'b0, 1'b1, 2'd0, 8'h00);
    check("R3", rd_valid, rd_data, 1'b1, 8'h5A);
    drive(1'b0, 1'b1, 2'd1, 8'h00);
    check("R3", rd_valid, rd_data, 1'b1, 8'hA5);
    drive(1'b0, 1'b1, 2'd3, 8'h00);
    check("R3", rd_valid, rd_data, 1'b1, 8'h44);

    // R1: a reset in mid-run clears all contents
    @(negedge clk);
    rst = 1'b1; save = 1'b0; load = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    for (int a = 0; a < 4; a++) begin
      drive(1'b0, 1'b1, 2'(a), 8'h00);
      check("R1", rd_valid, rd_data, 1'b1, 8'h00);
    end

    drive(1'b0, 1'b0, 2'd0, 8'h00);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule